// File: doc/BRIEF.md
# GPIO Edge Interrupt Unit

This block is a register-mapped general-purpose I/O port of 16 pins, meant to sit behind the register bus of a card-socket bridge. Each pin has a direction bit and an output bit. Each input passes through a two-stage synchronizer and then feeds an edge detector. Rising and falling transitions are tracked apart from each other. Each polarity has its own enable mask and its own sticky status register, and software clears a status bit by writing a one to it.

One interrupt line stays high while any status bit is set whose matching enable bit is also set. The bit positions have no fixed roles. Software chooses them. A card-ready pin uses a falling-edge enable to report card interrupts. A card-detect pin uses a falling-edge enable to report insertion, with its rising enable left clear. The power-control pins and the card-reset pin are made outputs through the direction register.

The bus side is a synchronous port with a word offset. Register words are big-endian on the bus, so the two bytes are exchanged on both writes and reads. Read data is registered and appears one clock after the read strobe.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset, every register reads zero, `pin_oe` and `pin_out` are all zero (every pin is an input), and `irq` is low.
- R2: Bus words are byte-swapped. Bus bits [15:8] carry internal bits [7:0] and bus bits [7:0] carry internal bits [15:8]. This holds for both writes and reads. Offsets are: 0 direction, 1 input data, 2 output data, 3 rising enable, 4 falling enable, 5 rising status, 6 falling status.
- R3: `pin_oe` equals the direction register and `pin_out` equals the output-data register. Each changes only on a write to its own offset.
- R4: A read strobe with an offset presents that register on `bus_rdata` after the next clock edge. The input-data register returns the pin levels after two synchronizer stages. `bus_rdata` holds its value when there is no read.
- R5: A low-to-high pin transition sets the matching rising-status bit when that rising-enable bit is set. A high-to-low transition sets the matching falling-status bit when that falling-enable bit is set.
- R6: A transition on a bit whose enable for that polarity is clear leaves that polarity's status bit unchanged.
- R7: Writing to a status offset clears each bit written as 1. Bits written as 0 keep their value.
- R8: When an enabled edge reaches a status bit in the same cycle that a clear write hits that bit, the bit ends up set.
- R9: `irq` is high exactly while some rising-status bit has its rising enable set, or some falling-status bit has its falling enable set. Clearing an enable drops `irq` while the status bit stays set.
- R10: Writes to the input-data offset have no effect. Offset 7 reads zero.
- R11: A pin change made between two clock edges raises `irq` after the third following rising clock edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register word offset |
| bus_wdata | input | 16 | Write data, big-endian byte order |
| bus_rdata | output | 16 | Registered read data, big-endian byte order |
| pin_in | input | 16 | Pin levels, asynchronous to clk |
| pin_out | output | 16 | Pin output values |
| pin_oe | output | 16 | Pin output enables |
| irq | output | 1 | Level interrupt |

## Verification
The hardest case to reach from the ports is an enabled edge arriving at a status bit in the very cycle that a clear write to that bit is sampled (R8). The stimulus first sets the bit with an earlier edge. It then changes the pin just after a falling clock edge, counts two more falling edges through the synchronizer, and drives the clear write so that the third rising edge samples both events at once. The same write also clears a neighbouring bit that sees no edge, which shows the write itself was accepted.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_DIR  = 3'd0,
    REG_DIN  = 3'd1,
    REG_DOUT = 3'd2,
    REG_REN  = 3'd3,
    REG_FEN  = 3'd4,
    REG_RSTS = 3'd5,
    REG_FSTS = 3'd6,
    REG_NONE = 3'd7
  } reg_sel_e;

  localparam int unsigned NUM_POL = 2;
  localparam int unsigned POL_RISE = 0;
  localparam int unsigned POL_FALL = 1;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= async_in;
      stab_q <= meta_q;
    end
  end

  assign sync_out = stab_q;
endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= level;
  end

  assign rise = level & ~prev_q;
  assign fall = ~level & prev_q;
endmodule

// File: rtl/gpio_w1c_sts.sv
module gpio_w1c_sts #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic         clr_en,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] sts
);
  logic [W-1:0] sts_q;
  logic [W-1:0] sts_d;
  logic [W-1:0] clr_eff;

  always_comb begin
    clr_eff = clr_en ? clr_mask : '0;
    sts_d   = (sts_q & ~clr_eff) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= sts_d;
  end

  assign sts = sts_q;
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gpio_edge_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      pin_in,
  output logic [W-1:0]      pin_out,
  output logic [W-1:0]      pin_oe,
  output logic              irq
);
  localparam int unsigned NB = W / 8;

  logic         rst_i_n;
  logic [W-1:0] wdata_int;
  logic [W-1:0] pin_sync;
  logic [W-1:0] rise_evt;
  logic [W-1:0] fall_evt;
  logic [W-1:0] dir_q, dir_d;
  logic [W-1:0] dout_q, dout_d;
  logic [W-1:0] rise_en_q, rise_en_d;
  logic [W-1:0] fall_en_q, fall_en_d;
  logic [W-1:0] rdata_q, rdata_d;
  logic [W-1:0] rise_sts;
  logic [W-1:0] fall_sts;
  logic         wr_dir, wr_dout, wr_ren, wr_fen, wr_rsts, wr_fsts;

  logic [NUM_POL-1:0][W-1:0] evt_v;
  logic [NUM_POL-1:0][W-1:0] en_v;
  logic [NUM_POL-1:0][W-1:0] sts_v;
  logic [NUM_POL-1:0]        clr_v;

  gpio_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  // Big-endian register words: byte lane b on the bus maps to lane NB-1-b inside.
  for (genvar b = 0; b < NB; b++) begin : g_swap
    assign wdata_int[b*8 +: 8] = bus_wdata[(NB-1-b)*8 +: 8];
    assign bus_rdata[b*8 +: 8] = rdata_q[(NB-1-b)*8 +: 8];
  end

  gpio_in_sync #(.W(W)) u_sync (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .async_in (pin_in),
    .sync_out (pin_sync)
  );

  gpio_edge_det #(.W(W)) u_edge (
    .clk   (clk),
    .rst_n (rst_i_n),
    .level (pin_sync),
    .rise  (rise_evt),
    .fall  (fall_evt)
  );

  // Write decode
  always_comb begin
    wr_dir  = bus_wr && (bus_addr == REG_DIR);
    wr_dout = bus_wr && (bus_addr == REG_DOUT);
    wr_ren  = bus_wr && (bus_addr == REG_REN);
    wr_fen  = bus_wr && (bus_addr == REG_FEN);
    wr_rsts = bus_wr && (bus_addr == REG_RSTS);
    wr_fsts = bus_wr && (bus_addr == REG_FSTS);
  end

  // Per-polarity status registers
  assign evt_v[POL_RISE] = rise_evt;
  assign evt_v[POL_FALL] = fall_evt;
  assign en_v[POL_RISE]  = rise_en_q;
  assign en_v[POL_FALL]  = fall_en_q;
  assign clr_v[POL_RISE] = wr_rsts;
  assign clr_v[POL_FALL] = wr_fsts;

  for (genvar p = 0; p < NUM_POL; p++) begin : g_pol
    gpio_w1c_sts #(.W(W)) u_sts (
      .clk      (clk),
      .rst_n    (rst_i_n),
      .set_vec  (evt_v[p] & en_v[p]),
      .clr_en   (clr_v[p]),
      .clr_mask (wdata_int),
      .sts      (sts_v[p])
    );
  end

  assign rise_sts = sts_v[POL_RISE];
  assign fall_sts = sts_v[POL_FALL];

  // Next state of the control registers and read data
  always_comb begin
    dir_d     = wdata_int;
    dout_d    = wdata_int;
    rise_en_d = wdata_int;
    fall_en_d = wdata_int;
    rdata_d   = '0;
    case (bus_addr)
      REG_DIR:  rdata_d = dir_q;
      REG_DIN:  rdata_d = pin_sync;
      REG_DOUT: rdata_d = dout_q;
      REG_REN:  rdata_d = rise_en_q;
      REG_FEN:  rdata_d = fall_en_q;
      REG_RSTS: rdata_d = rise_sts;
      REG_FSTS: rdata_d = fall_sts;
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      dir_q     <= '0;
      dout_q    <= '0;
      rise_en_q <= '0;
      fall_en_q <= '0;
      rdata_q   <= '0;
    end else begin
      if (wr_dir)  dir_q     <= dir_d;
      if (wr_dout) dout_q    <= dout_d;
      if (wr_ren)  rise_en_q <= rise_en_d;
      if (wr_fen)  fall_en_q <= fall_en_d;
      if (bus_rd)  rdata_q   <= rdata_d;
    end
  end

  assign pin_oe  = dir_q;
  assign pin_out = dout_q;
  assign irq     = |((rise_sts & rise_en_q) | (fall_sts & fall_en_q));
endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk
  import gpio_edge_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [W-1:0]      bus_wdata,
  input logic [W-1:0]      bus_rdata,
  input logic [W-1:0]      pin_oe,
  input logic              irq,
  input logic [W-1:0]      rise_en,
  input logic [W-1:0]      fall_en,
  input logic [W-1:0]      rise_sts,
  input logic [W-1:0]      fall_sts,
  input logic [W-1:0]      rise_evt,
  input logic [W-1:0]      fall_evt
);
  localparam int unsigned NB = W / 8;

  logic [W-1:0] wd_int;
  logic [W-1:0] rclr;
  logic [W-1:0] fclr;

  always_comb begin
    for (int b = 0; b < NB; b++) wd_int[b*8 +: 8] = bus_wdata[(NB-1-b)*8 +: 8];
    rclr = (bus_wr && bus_addr == REG_RSTS) ? wd_int : '0;
    fclr = (bus_wr && bus_addr == REG_FSTS) ? wd_int : '0;
  end

  p_dir_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == REG_DIR) |=> $stable(pin_oe));

  p_rdata_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

  p_rise_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((rise_sts & ~$past(rise_sts) & ~$past(rise_en)) == '0));

  p_fall_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((fall_sts & ~$past(fall_sts) & ~$past(fall_en)) == '0));

  p_rise_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(rise_sts) & ~$past(rclr) & ~rise_sts) == '0));

  p_fall_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(fall_sts) & ~$past(fclr) & ~fall_sts) == '0));

  p_rise_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(rise_evt & rise_en) & ~rise_sts) == '0));

  p_fall_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(fall_evt & fall_en) & ~fall_sts) == '0));

  p_irq_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((rise_sts | fall_sts) != '0));
endmodule

bind gpio_edge_irq gpio_edge_irq_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pin_oe    (pin_oe),
  .irq       (irq),
  .rise_en   (rise_en_q),
  .fall_en   (fall_en_q),
  .rise_sts  (rise_sts),
  .fall_sts  (fall_sts),
  .rise_evt  (rise_evt),
  .fall_evt  (fall_evt)
);

// File: tb/tb_gpio_edge_irq.sv
module tb_gpio_edge_irq;
  localparam int CLK_PERIOD = 10;

  localparam logic [2:0] A_DIR  = 3'd0;
  localparam logic [2:0] A_DIN  = 3'd1;
  localparam logic [2:0] A_DOUT = 3'd2;
  localparam logic [2:0] A_REN  = 3'd3;
  localparam logic [2:0] A_FEN  = 3'd4;
  localparam logic [2:0] A_RSTS = 3'd5;
  localparam logic [2:0] A_FSTS = 3'd6;
  localparam logic [2:0] A_NONE = 3'd7;

  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic        bus_rd;
  logic [2:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic [15:0] pin_in;
  logic [15:0] pin_out;
  logic [15:0] pin_oe;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  gpio_edge_irq dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq       (irq)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr    = 1'b1;
    bus_addr  = a;
    bus_wdata = {d[7:0], d[15:8]};
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_rd   = 1'b1;
    bus_addr = a;
    @(negedge clk);
    bus_rd   = 1'b0;
    d = {bus_rdata[7:0], bus_rdata[15:8]};
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    chk("R1 pin_oe", pin_oe, 16'h0000);
    chk("R1 pin_out", pin_out, 16'h0000);
    chk("R1 irq", {15'd0, irq}, 16'h0000);
    for (int a = 0; a < 7; a++) begin
      bus_read(3'(a), v);
      chk("R1 register reset", v, 16'h0000);
    end
  endtask

  task automatic t_swap_dir();
    logic [15:0] v;
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = A_DOUT; bus_wdata = 16'h00C3;
    @(negedge clk);
    bus_wr = 1'b0;
    chk("R2 raw write lands byte-swapped", pin_out, 16'hC300);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = A_DOUT;
    @(negedge clk);
    bus_rd = 1'b0;
    chk("R2 raw read byte-swapped", bus_rdata, 16'h00C3);
    bus_write(A_DIR, 16'h1234);
    chk("R3 pin_oe follows direction", pin_oe, 16'h1234);
    chk("R3 pin_out unchanged by dir write", pin_out, 16'hC300);
    bus_write(A_DOUT, 16'h00A5);
    chk("R3 pin_out follows data-out", pin_out, 16'h00A5);
    bus_read(A_DIR, v);
    chk("R4 direction read back", v, 16'h1234);
  endtask

  task automatic t_din();
    logic [15:0] v;
    pin_in = 16'hBEEF;
    settle();
    bus_read(A_DIN, v);
    chk("R4 input data read", v, 16'hBEEF);
    bus_write(A_DIN, 16'h0000);
    bus_read(A_DIN, v);
    chk("R10 input data write ignored", v, 16'hBEEF);
    bus_read(A_NONE, v);
    chk("R10 offset 7 reads zero", v, 16'h0000);
    bus_read(A_RSTS, v);
    chk("R6 edges with enables clear not latched", v, 16'h0000);
    pin_in = 16'h0000;
    settle();
    bus_read(A_FSTS, v);
    chk("R6 falling edges not latched", v, 16'h0000);
  endtask

  task automatic t_rise();
    logic [15:0] v;
    bus_write(A_REN, 16'h0008);
    pin_in[3] = 1'b1;
    @(negedge clk);
    chk("R11 irq low after edge 1", {15'd0, irq}, 16'h0000);
    @(negedge clk);
    chk("R11 irq low after edge 2", {15'd0, irq}, 16'h0000);
    @(negedge clk);
    chk("R11 irq high after edge 3", {15'd0, irq}, 16'h0001);
    bus_read(A_RSTS, v);
    chk("R5 rising status set", v, 16'h0008);
    bus_read(A_FSTS, v);
    chk("R5 falling status untouched by rise", v, 16'h0000);
  endtask

  task automatic t_fall_disabled();
    logic [15:0] v;
    pin_in[3] = 1'b0;
    settle();
    bus_read(A_FSTS, v);
    chk("R6 disabled fall not latched", v, 16'h0000);
    chk("R9 irq held by rising status", {15'd0, irq}, 16'h0001);
  endtask

  task automatic t_w1c();
    logic [15:0] v;
    bus_write(A_RSTS, 16'h0000);
    bus_write(A_RSTS, 16'hFFF7);
    bus_read(A_RSTS, v);
    chk("R7 zeros leave status", v, 16'h0008);
    bus_write(A_RSTS, 16'h0008);
    bus_read(A_RSTS, v);
    chk("R7 one clears status", v, 16'h0000);
    chk("R9 irq low after clear", {15'd0, irq}, 16'h0000);
  endtask

  task automatic t_mask();
    logic [15:0] v;
    bus_write(A_FEN, 16'h0200);
    pin_in[9] = 1'b1;
    settle();
    chk("R6 rise on bit 9 without rise enable", {15'd0, irq}, 16'h0000);
    pin_in[9] = 1'b0;
    settle();
    chk("R9 irq from falling status", {15'd0, irq}, 16'h0001);
    bus_read(A_FSTS, v);
    chk("R5 falling status set", v, 16'h0200);
    bus_write(A_FEN, 16'h0000);
    chk("R9 irq drops with enable", {15'd0, irq}, 16'h0000);
    bus_read(A_FSTS, v);
    chk("R9 status kept after enable cleared", v, 16'h0200);
    bus_write(A_FSTS, 16'h0200);
    bus_read(A_FSTS, v);
    chk("R7 falling status cleared", v, 16'h0000);
  endtask

  task automatic t_collide();
    logic [15:0] v;
    bus_write(A_REN, 16'h0060);
    pin_in[5] = 1'b1;
    pin_in[6] = 1'b1;
    settle();
    bus_read(A_RSTS, v);
    chk("R5 bits 5 and 6 set", v, 16'h0060);
    pin_in[5] = 1'b0;
    settle();
    pin_in[5] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = A_RSTS; bus_wdata = 16'h6000;
    @(negedge clk);
    bus_wr = 1'b0;
    bus_read(A_RSTS, v);
    chk("R8 edge beats same-cycle clear", v, 16'h0020);
    chk("R9 irq still high", {15'd0, irq}, 16'h0001);
  endtask

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_addr = '0; bus_wdata = '0; pin_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_swap_dir();
    t_din();
    t_rise();
    t_fall_disabled();
    t_w1c();
    t_mask();
    t_collide();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %h expected %h", 16'h0000, 16'h0001);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule